// File: doc/BRIEF.md
# Side Rewrite Gap Injector

This block sits beside the bitstream generator of a floppy drive emulator. During a whole-side formatting pass it watches the host's sector writes. When a side is completed for the first time, the block arranges that the gap shown after the last sector has the wrong size. The host measures that gap once it drops into read mode, finds it bad, and writes the side a second time. The extra pass gives slow storage behind the emulator time to save the side. The host takes one step off a progress counter for each bad gap and one step back for each side that passes, and it gives up once the counter falls too low. For that reason each side is poisoned at most once. Injection therefore lands on every other side completion.

During the second pass, a sector whose payload already matches the stored copy needs no second save. The block raises a one-cycle suppress pulse for such sectors. Side completion depends on the zone: the outer tracks hold more sectors than the inner ones, and a side is complete when the highest sector index of the current track's zone is written. A pass that starts again at the first sector of track 0, side 0 clears every per-side mark.

Top module: `side_gap_injector`

## Requirements
- R1: After reset, `gap_bad` and `save_drop` are 0 and every side is unmarked. An asserted reset in mid-run also discards any armed injection and all marks.
- R2: A side is complete when sector index `SECT_OUTER-1-track/ZONE_TRACKS` is written (defaults: 11 on tracks 0-15, 10 on 16-31, down to 7 on 64-79, 0-based). Other indices neither complete nor arm.
- R3: A completion write to an unmarked side marks that side and arms one injection.
- R4: `gap_bad` rises one cycle after `rd_enter` is sampled while an injection is armed. It then holds, and falls one cycle after `hdr_done` is sampled.
- R5: A completion write to a side that is already marked does not arm. A following `rd_enter` leaves `gap_bad` at 0.
- R6: `save_drop` is 1 for exactly the cycle after a `wr_evt` whose side was marked before that write and whose `wr_match` is 1. In every other cycle it is 0.
- R7: Marks are kept per track and side. Marking one side changes no other side.
- R8: A write to track 0, side 0, sector 0 clears all marks if the previous write went to any other side. That write itself gives `save_drop` 0.
- R9: A write to track 0, side 0, sector 0 that follows a write to track 0, side 0 keeps the marks.
- R10: A write event that does not arm cancels an injection that is armed but not yet shown.
- R11: `rd_enter` with nothing armed, and `hdr_done` while `gap_bad` is 0, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_evt | input | 1 | One-cycle pulse: host wrote a sector |
| wr_track | input | 7 | Track of the written sector |
| wr_side | input | 1 | Side of the written sector |
| wr_sect | input | 4 | Sector index, 0-based |
| wr_match | input | 1 | Written payload equals the stored copy |
| rd_enter | input | 1 | One-cycle pulse: host entered read mode |
| hdr_done | input | 1 | One-cycle pulse: generator emitted a sector header |
| gap_bad | output | 1 | Select the wrong-size gap |
| save_drop | output | 1 | Skip saving the sector just written |

## Verification
A mark that is set wrongly or lost shows up in two places. It changes `save_drop` on the cycle right after the next write to that side. It also shows up as a missing or extra `gap_bad` pulse after the next `rd_enter`, once that side completes again. A wrong zone boundary shows as a completion write that is followed by no gap, or a gap raised after a non-final sector. In each case the fault is visible at the ports within one cycle of the host's next read-mode entry. A stuck armed state shows as `gap_bad` rising on a read entry that should be inert.

// File: rtl/gi_pkg.sv
package gi_pkg;
  // Highest sector index of the zone that holds a track.
  function automatic int unsigned last_sector(input int unsigned trk,
                                              input int unsigned zone_tracks,
                                              input int unsigned sect_outer);
    return sect_outer - 1 - (trk / zone_tracks);
  endfunction
endpackage

// File: rtl/gi_zone.sv
module gi_zone #(
  parameter int TRACKS      = 80,
  parameter int ZONE_TRACKS = 16,
  parameter int SECT_OUTER  = 12,
  localparam int TRK_W = $clog2(TRACKS),
  localparam int SEC_W = $clog2(SECT_OUTER)
) (
  input  logic [TRK_W-1:0] track,
  input  logic [SEC_W-1:0] sect,
  output logic             is_last
);
  import gi_pkg::*;
  logic [SEC_W-1:0] last_idx;

  // R2: zone-dependent final sector index
  always_comb begin
    last_idx = SEC_W'(last_sector(int'(track), ZONE_TRACKS, SECT_OUTER));
    is_last  = (sect == last_idx);
  end
endmodule

// File: rtl/gi_flags.sv
module gi_flags #(
  parameter int NSIDES = 160,
  localparam int IDX_W = $clog2(NSIDES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             set_en,
  input  logic [IDX_W-1:0] idx,
  output logic             mark
);
  logic [NSIDES-1:0] mark_q, mark_d;

  assign mark = mark_q[idx];

  // R7 per-side marks, R8 bulk clear
  always_comb begin
    mark_d = mark_q;
    if (clr_all) mark_d = '0;
    if (set_en)  mark_d[idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                mark_q <= '0;
    else if (clr_all || set_en) mark_q <= mark_d;
  end
endmodule

// File: rtl/gi_gap.sv
module gi_gap (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic cancel,
  input  logic rd_enter,
  input  logic hdr_done,
  output logic gap_bad
);
  logic pend_q, pend_d, gap_q, gap_d;

  always_comb begin
    pend_d = pend_q;
    gap_d  = gap_q;
    if (arm)                        pend_d = 1'b1;          // R3
    else if (cancel)                pend_d = 1'b0;          // R10
    else if (rd_enter && pend_q)    pend_d = 1'b0;
    if (rd_enter && pend_q && !arm) gap_d = 1'b1;           // R4
    else if (hdr_done)              gap_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      gap_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      gap_q  <= gap_d;
    end
  end

  assign gap_bad = gap_q;
endmodule

// File: rtl/side_gap_injector.sv
module side_gap_injector #(
  parameter int TRACKS      = 80,
  parameter int SIDES       = 2,
  parameter int ZONE_TRACKS = 16,
  parameter int SECT_OUTER  = 12,
  localparam int TRK_W  = $clog2(TRACKS),
  localparam int SEC_W  = $clog2(SECT_OUTER),
  localparam int NSIDES = TRACKS * SIDES,
  localparam int IDX_W  = $clog2(NSIDES),
  localparam int SID_W  = (SIDES > 1) ? $clog2(SIDES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_evt,
  input  logic [TRK_W-1:0] wr_track,
  input  logic [SID_W-1:0] wr_side,
  input  logic [SEC_W-1:0] wr_sect,
  input  logic             wr_match,
  input  logic             rd_enter,
  input  logic             hdr_done,
  output logic             gap_bad,
  output logic             save_drop
);
  logic             is_last, mark, restart, arm, cancel;
  logic [IDX_W-1:0] idx;
  logic [TRK_W-1:0] prev_trk_q;
  logic [SID_W-1:0] prev_side_q;
  logic             drop_q, drop_d;

  gi_zone #(.TRACKS(TRACKS), .ZONE_TRACKS(ZONE_TRACKS), .SECT_OUTER(SECT_OUTER)) u_zone (
    .track(wr_track), .sect(wr_sect), .is_last(is_last));

  always_comb begin
    idx     = IDX_W'(int'(wr_track) * SIDES + int'(wr_side));
    // R8/R9: new pass starts at the first sector of the first side
    restart = wr_evt && (wr_track == '0) && (wr_side == '0) && (wr_sect == '0) &&
              !((prev_trk_q == '0) && (prev_side_q == '0));
    arm     = wr_evt && is_last && !mark && !restart;   // R3, R5
    cancel  = wr_evt && !arm;                           // R10
    drop_d  = wr_evt && mark && wr_match && !restart;   // R6
  end

  gi_flags #(.NSIDES(NSIDES)) u_flags (
    .clk(clk), .rst_n(rst_n), .clr_all(restart), .set_en(arm),
    .idx(idx), .mark(mark));

  gi_gap u_gap (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cancel(cancel),
    .rd_enter(rd_enter), .hdr_done(hdr_done), .gap_bad(gap_bad));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_trk_q  <= '0;
      prev_side_q <= '0;
      drop_q      <= 1'b0;
    end else begin
      drop_q <= drop_d;
      if (wr_evt) begin
        prev_trk_q  <= wr_track;
        prev_side_q <= wr_side;
      end
    end
  end

  assign save_drop = drop_q;
endmodule

// File: rtl/gi_checker.sv
module gi_checker (
  input logic clk,
  input logic rst_n,
  input logic wr_evt,
  input logic wr_match,
  input logic rd_enter,
  input logic hdr_done,
  input logic gap_bad,
  input logic save_drop
);
  p_gap_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gap_bad) |-> $past(rd_enter));
  p_gap_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_bad && hdr_done && !rd_enter) |=> !gap_bad);
  p_gap_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_bad && !hdr_done) |=> gap_bad);
  p_drop_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    save_drop |-> $past(wr_evt && wr_match));
  p_drop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |=> !save_drop);
endmodule

bind side_gap_injector gi_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_match(wr_match),
  .rd_enter(rd_enter), .hdr_done(hdr_done), .gap_bad(gap_bad),
  .save_drop(save_drop));

// File: tb/sim_side_gap_injector.sv
module sim_side_gap_injector;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_evt = 1'b0, wr_side = 1'b0, wr_match = 1'b0;
  logic       rd_enter = 1'b0, hdr_done = 1'b0;
  logic [6:0] wr_track = '0;
  logic [3:0] wr_sect = '0;
  logic       gap_bad, save_drop;
  int         total = 0, bad = 0;

  always #10 clk = ~clk;

  side_gap_injector u0 (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_track(wr_track),
    .wr_side(wr_side), .wr_sect(wr_sect), .wr_match(wr_match),
    .rd_enter(rd_enter), .hdr_done(hdr_done), .gap_bad(gap_bad),
    .save_drop(save_drop));

  // {kind(0 wr,1 rd,2 hdr), track, side, sect, match, exp_drop, exp_gap, req}
  localparam int NV = 23;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 7'd5,  1'b0, 4'd11, 1'b1, 1'b0, 1'b0, 5'd3},  // R3 first completion arms
    {2'd1, 7'd0,  1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 5'd4},  // R4 gap rises
    {2'd1, 7'd0,  1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 5'd4},  // R4 holds
    {2'd2, 7'd0,  1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 5'd4},  // R4 falls on header
    {2'd2, 7'd0,  1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 5'd11}, // R11 header idle
    {2'd0, 7'd5,  1'b0, 4'd0,  1'b1, 1'b1, 1'b0, 5'd6},  // R6 rewrite match
    {2'd0, 7'd5,  1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 5'd6},  // R6 rewrite mismatch
    {2'd0, 7'd5,  1'b0, 4'd11, 1'b1, 1'b1, 1'b0, 5'd5},  // R5 second completion
    {2'd1, 7'd0,  1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 5'd5},  // R5 no gap
    {2'd0, 7'd5,  1'b1, 4'd3,  1'b1, 1'b0, 1'b0, 5'd7},  // R7 other side clean
    {2'd0, 7'd5,  1'b1, 4'd10, 1'b0, 1'b0, 1'b0, 5'd2},  // R2 not final in zone 0
    {2'd1, 7'd0,  1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 5'd11}, // R11 read with nothing armed
    {2'd0, 7'd16, 1'b1, 4'd10, 1'b0, 1'b0, 1'b0, 5'd2},  // R2 final in zone 1
    {2'd1, 7'd0,  1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 5'd2},
    {2'd2, 7'd0,  1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 5'd4},
    {2'd0, 7'd79, 1'b0, 4'd7,  1'b0, 1'b0, 1'b0, 5'd2},  // R2 final in zone 4
    {2'd0, 7'd79, 1'b0, 4'd0,  1'b1, 1'b1, 1'b0, 5'd10}, // R10 write cancels
    {2'd1, 7'd0,  1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 5'd10},
    {2'd0, 7'd0,  1'b0, 4'd0,  1'b1, 1'b0, 1'b0, 5'd8},  // R8 restart clears
    {2'd0, 7'd5,  1'b0, 4'd0,  1'b1, 1'b0, 1'b0, 5'd8},  // R8 old mark gone
    {2'd0, 7'd0,  1'b0, 4'd11, 1'b0, 1'b0, 1'b0, 5'd3},
    {2'd1, 7'd0,  1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 5'd4},
    {2'd0, 7'd0,  1'b0, 4'd0,  1'b1, 1'b1, 1'b1, 5'd9}   // R9 same side keeps mark
  };

  task automatic check(input string req, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; pulses one cycle and checks after the rising edge.
  task automatic step(input logic [1:0] kind, input logic [6:0] t, input logic s,
                      input logic [3:0] sc, input logic m);
    wr_evt   = (kind == 2'd0);
    rd_enter = (kind == 2'd1);
    hdr_done = (kind == 2'd2);
    wr_track = t; wr_side = s; wr_sect = sc; wr_match = m;
    @(negedge clk);
    wr_evt = 1'b0; rd_enter = 1'b0; hdr_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", gap_bad, 1'b0, "gap_bad in reset");
    check("R1", save_drop, 1'b0, "save_drop in reset");
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i][4:0]);
      step(VEC[i][21:20], VEC[i][19:13], VEC[i][12], VEC[i][11:8], VEC[i][7]);
      check(rq, save_drop, VEC[i][6], $sformatf("save_drop v%0d", i));
      check(rq, gap_bad, VEC[i][5], $sformatf("gap_bad v%0d", i));
    end
    // R6: drop is a single-cycle pulse
    @(negedge clk);
    check("R6", save_drop, 1'b0, "save_drop idle cycle");
    step(2'd2, 7'd0, 1'b0, 4'd0, 1'b0);
    check("R4", gap_bad, 1'b0, "gap_bad after header");
    // R1: mid-run reset clears arming and marks
    step(2'd0, 7'd40, 1'b1, 4'd9, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", gap_bad, 1'b0, "gap_bad during reset");
    rst_n = 1'b1;
    @(negedge clk);
    step(2'd1, 7'd0, 1'b0, 4'd0, 1'b0);
    check("R1", gap_bad, 1'b0, "arming dropped by reset");
    step(2'd0, 7'd40, 1'b1, 4'd2, 1'b1);
    check("R1", save_drop, 1'b0, "mark dropped by reset");
    // R2: zone 2 final index 9; index 10 there is not final
    step(2'd0, 7'd47, 1'b0, 4'd10, 1'b0);
    step(2'd1, 7'd0, 1'b0, 4'd0, 1'b0);
    check("R2", gap_bad, 1'b0, "index 10 on track 47");
    step(2'd0, 7'd47, 1'b0, 4'd9, 1'b0);
    step(2'd1, 7'd0, 1'b0, 4'd0, 1'b0);
    check("R2", gap_bad, 1'b1, "index 9 on track 47");
    step(2'd2, 7'd0, 1'b0, 4'd0, 1'b0);
    check("R4", gap_bad, 1'b0, "gap cleared");
    // R7: neighbouring track unaffected
    step(2'd0, 7'd48, 1'b0, 4'd1, 1'b1);
    check("R7", save_drop, 1'b0, "track 48 unmarked");
    step(2'd0, 7'd47, 1'b0, 4'd1, 1'b1);
    check("R7", save_drop, 1'b1, "track 47 marked");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule